// File: doc/BRIEF.md
# Sequential Sign-Correcting Word Multiplier

This block multiplies two operands that are each two "halves" wide: 16 bits at the default half width of 8. It produces a product twice the operand width. There is one narrow unsigned half-by-half multiplier, and the block reuses it over several clock cycles.

Each operand is split into an upper half and a lower half. The four half products are computed in a fixed order: low·low, high·high, first-low·second-high, then first-high·second-low. Each product is placed in, or added into, a product register at its weight. The lower-times-lower and upper-times-upper products are written directly. The two cross products are added one half-width above the bottom, with the carry running up to the top.

When signed mode is selected, up to two correction steps follow. If the second operand is negative, the first operand is subtracted from the upper half of the product. If the first operand is negative, the second operand is subtracted from the upper half. Every sum wraps at the product width, so the register ends with the exact two's-complement product in signed mode and the exact unsigned product otherwise.

Operands enter through a valid/ready request channel:
- `in_ready` is high only while the block is idle.
- A request is taken on a clock edge where both `in_valid` and `in_ready` are high.
- Requests offered while the block is working are not taken.

The product leaves through a valid/ready result channel:
- `out_valid` stays high, with `out_prod` frozen, until the consumer raises `out_ready`.
- This back-pressure stalls the block. No new request is taken until the result has been consumed.

`busy` is a plain status pin that is high whenever a request is in progress or waiting for the consumer.

Top module: `seq_mul_signed`

## Requirements
- R1: After reset, `out_valid` and `busy` are 0 and `in_ready` is 1.
- R2: With `in_signed` = 0 at acceptance, `out_prod` equals the unsigned product of `in_a` and `in_b`, including zero operands and all-ones operands.
- R3: With `in_signed` = 1 at acceptance, `out_prod` equals the two's-complement product of `in_a` and `in_b` modulo 2^(4·HALF_W), including the most-negative value times itself and -1 times -1.
- R4: `out_valid` first rises exactly 4 clock edges after the accepting edge in unsigned mode and exactly 6 in signed mode.
- R5: From the accepting edge until the result is consumed, `in_ready` is 0 and `busy` is 1. Any `in_valid`, operand or mode activity in that window does not change the result delivered.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_prod` holds its value.
- R7: On an edge with `out_valid` and `out_ready` both 1, the block returns to idle: the next cycle has `out_valid` = 0, `busy` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block idle and able to take a request |
| in_a | input | 2·HALF_W | First operand |
| in_b | input | 2·HALF_W | Second operand |
| in_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| busy | output | 1 | Request in progress or result pending |
| out_valid | output | 1 | Product available |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 4·HALF_W | Product |

## Verification
The bench builds two copies of the block.

- A copy with HALF_W = 3 takes 6-bit operands. Its full operand space of 64 × 64 pairs fits in the run, so it is swept completely in both modes. That sweep reaches every sign combination, every carry out of the cross-product additions and every pair of corrections.
- A copy at the default HALF_W = 8 runs the named 16-bit corner pairs (0x8000², 0xFFFF², zero operands) and a pseudo-random spread of operands. It also takes the back-pressure, ignored-request and mid-operation mode-change scenarios.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;
  // Work steps in schedule order; the correction steps run only in signed mode.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOLO  = 3'd1,
    ST_HIHI  = 3'd2,
    ST_LOHI  = 3'd3,
    ST_HILO  = 3'd4,
    ST_FIXB  = 3'd5,  // second operand negative: take first operand off upper half
    ST_FIXA  = 3'd6,  // first operand negative: take second operand off upper half
    ST_DONE  = 3'd7
  } step_e;
endpackage

// File: rtl/seq_mul_half.sv
// Unsigned HALF_W x HALF_W multiplier built as a shift-and-add row array.
module seq_mul_half #(
  parameter int HALF_W = 8
) (
  input  logic [HALF_W-1:0]   x,
  input  logic [HALF_W-1:0]   y,
  output logic [2*HALF_W-1:0] p
);
  localparam int PW = 2 * HALF_W;

  logic [PW-1:0] rows [HALF_W];

  for (genvar i = 0; i < HALF_W; i++) begin : g_row
    assign rows[i] = y[i] ? ({{HALF_W{1'b0}}, x} << i) : '0;
  end

  always_comb begin
    p = '0;
    for (int k = 0; k < HALF_W; k++) begin
      p = p + rows[k];
    end
  end
endmodule

// File: rtl/seq_mul_ctrl.sv
// Step sequencer: walks the fixed partial-product schedule.
module seq_mul_ctrl
  import seq_mul_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,       // request handshake this edge
  input  logic  mode_q,     // latched signed mode
  input  logic  out_ready,
  output step_e step
);
  step_e step_nx;

  always_comb begin
    step_nx = step;
    unique case (step)
      ST_IDLE: if (take) step_nx = ST_LOLO;
      ST_LOLO: step_nx = ST_HIHI;
      ST_HIHI: step_nx = ST_LOHI;
      ST_LOHI: step_nx = ST_HILO;
      ST_HILO: step_nx = mode_q ? ST_FIXB : ST_DONE;
      ST_FIXB: step_nx = ST_FIXA;
      ST_FIXA: step_nx = ST_DONE;
      ST_DONE: if (out_ready) step_nx = ST_IDLE;
      default: step_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_IDLE;
    else        step <= step_nx;
  end
endmodule

// File: rtl/seq_mul_opsel.sv
// Picks which operand halves feed the shared multiplier for each step.
module seq_mul_opsel
  import seq_mul_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  step_e                 step,
  input  logic [2*HALF_W-1:0]   a_q,
  input  logic [2*HALF_W-1:0]   b_q,
  output logic [HALF_W-1:0]     x,
  output logic [HALF_W-1:0]     y
);
  logic [HALF_W-1:0] a_lo, a_hi, b_lo, b_hi;

  assign a_lo = a_q[HALF_W-1:0];
  assign a_hi = a_q[2*HALF_W-1:HALF_W];
  assign b_lo = b_q[HALF_W-1:0];
  assign b_hi = b_q[2*HALF_W-1:HALF_W];

  always_comb begin
    unique case (step)
      ST_HIHI: begin x = a_hi; y = b_hi; end
      ST_LOHI: begin x = a_lo; y = b_hi; end
      ST_HILO: begin x = a_hi; y = b_lo; end
      default: begin x = a_lo; y = b_lo; end
    endcase
  end
endmodule

// File: rtl/seq_mul_acc.sv
// Product register: direct writes, offset additions and upper-half corrections.
module seq_mul_acc
  import seq_mul_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  step_e                 step,
  input  logic [2*HALF_W-1:0]   a_q,
  input  logic [2*HALF_W-1:0]   b_q,
  input  logic [2*HALF_W-1:0]   pp,
  output logic [4*HALF_W-1:0]   prod
);
  localparam int OW = 2 * HALF_W;
  localparam int RW = 4 * HALF_W;

  logic [RW-1:0] cross_add;
  logic [OW-1:0] fix_val;
  logic [RW-1:0] prod_nx;

  // Cross product lands one half above the bottom; carries wrap at RW.
  assign cross_add = {{OW{1'b0}}, pp} << HALF_W;

  always_comb begin
    fix_val = '0;
    if (step == ST_FIXB && b_q[OW-1]) fix_val = a_q;
    if (step == ST_FIXA && a_q[OW-1]) fix_val = b_q;
  end

  always_comb begin
    prod_nx = prod;
    unique case (step)
      ST_LOLO: prod_nx[OW-1:0]  = pp;
      ST_HIHI: prod_nx[RW-1:OW] = pp;
      ST_LOHI,
      ST_HILO: prod_nx = prod + cross_add;
      ST_FIXB,
      ST_FIXA: prod_nx[RW-1:OW] = prod[RW-1:OW] - fix_val;
      default: prod_nx = prod;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod <= '0;
    else        prod <= prod_nx;
  end
endmodule

// File: rtl/seq_mul_signed.sv
module seq_mul_signed
  import seq_mul_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*HALF_W-1:0]   in_a,
  input  logic [2*HALF_W-1:0]   in_b,
  input  logic                  in_signed,
  output logic                  busy,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [4*HALF_W-1:0]   out_prod
);
  localparam int OW = 2 * HALF_W;

  step_e             step;
  logic              take;
  logic [OW-1:0]     a_q, b_q;
  logic              mode_q;
  logic [HALF_W-1:0] mx, my;
  logic [OW-1:0]     pp;

  assign in_ready  = (step == ST_IDLE);
  assign take      = in_valid && in_ready;
  assign busy      = (step != ST_IDLE);
  assign out_valid = (step == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= 1'b0;
    end else if (take) begin
      a_q    <= in_a;
      b_q    <= in_b;
      mode_q <= in_signed;
    end
  end

  seq_mul_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .mode_q    (mode_q),
    .out_ready (out_ready),
    .step      (step)
  );

  seq_mul_opsel #(.HALF_W(HALF_W)) u_opsel (
    .step (step),
    .a_q  (a_q),
    .b_q  (b_q),
    .x    (mx),
    .y    (my)
  );

  seq_mul_half #(.HALF_W(HALF_W)) u_half (
    .x (mx),
    .y (my),
    .p (pp)
  );

  seq_mul_acc #(.HALF_W(HALF_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .a_q   (a_q),
    .b_q   (b_q),
    .pp    (pp),
    .prod  (out_prod)
  );
endmodule

// File: rtl/seq_mul_chk.sv
module seq_mul_chk #(
  parameter int HALF_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [2*HALF_W-1:0] in_a,
  input logic [2*HALF_W-1:0] in_b,
  input logic                in_signed,
  input logic                busy,
  input logic                out_valid,
  input logic                out_ready,
  input logic [4*HALF_W-1:0] out_prod
);
  localparam int OW = 2 * HALF_W;
  localparam int RW = 4 * HALF_W;

  logic          acc_seen;
  logic [OW-1:0] ca, cb;
  logic          cmode;
  logic [3:0]    lat;
  logic [RW-1:0] ref_u, ref_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ca <= '0; cb <= '0; cmode <= 1'b0; lat <= '0; acc_seen <= 1'b0;
    end else if (in_valid && in_ready) begin
      ca <= in_a; cb <= in_b; cmode <= in_signed; lat <= '0; acc_seen <= 1'b1;
    end else if (busy && !out_valid) begin
      lat <= lat + 4'd1;
    end
  end

  assign ref_u = {{OW{1'b0}}, ca} * {{OW{1'b0}}, cb};
  assign ref_s = $unsigned($signed({{OW{ca[OW-1]}}, ca}) * $signed({{OW{cb[OW-1]}}, cb}));

  // R1
  always_comb if (!rst_n) reset_idle_chk: assert (!out_valid && !busy && in_ready);

  // R2
  unsigned_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && acc_seen && !cmode) |-> out_prod == ref_u);

  // R3
  signed_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_valid) && acc_seen && cmode) |-> out_prod == ref_s);

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat == (cmode ? 4'd6 : 4'd4));

  // R5
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !in_ready));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && !busy && in_ready));
endmodule

bind seq_mul_signed seq_mul_chk #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_a      (in_a),
  .in_b      (in_b),
  .in_signed (in_signed),
  .busy      (busy),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_prod  (out_prod)
);

// File: tb/tb_seq_mul_signed.sv
`timescale 1ns/1ps
module tb_seq_mul_signed;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  // default-width copy
  logic        in_valid = 0, in_signed = 0, out_ready = 1;
  logic [15:0] in_a = 0, in_b = 0;
  logic        in_ready, busy, out_valid;
  logic [31:0] out_prod;

  seq_mul_signed dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_signed(in_signed), .busy(busy),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  // small copy for the exhaustive sweep
  logic        s_valid = 0, s_signed = 0;
  logic [5:0]  s_a = 0, s_b = 0;
  logic        s_ready, s_busy, s_ovalid;
  logic [11:0] s_prod;

  seq_mul_signed #(.HALF_W(3)) dut_small (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready),
    .in_a(s_a), .in_b(s_b), .in_signed(s_signed), .busy(s_busy),
    .out_valid(s_ovalid), .out_ready(1'b1), .out_prod(s_prod)
  );

  function automatic longint ref_prod(longint a, longint b, bit sg, int ow);
    longint av = a, bv = b;
    longint mask = (longint'(1) << (2 * ow)) - 1;
    if (sg && a[ow-1]) av = a - (longint'(1) << ow);
    if (sg && b[ow-1]) bv = b - (longint'(1) << ow);
    return (av * bv) & mask;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Runs one request on the default copy; hold = cycles of back-pressure.
  task automatic run_op(logic [15:0] a, logic [15:0] b, bit sg, int hold, bit poke);
    int n = 0;
    longint e = ref_prod(a, b, sg, 16);
    @(negedge clk);
    in_a = a; in_b = b; in_signed = sg; in_valid = 1; out_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    if (poke) begin
      // R5: traffic and mode flip while working
      in_a = ~a; in_b = a ^ b; in_signed = ~sg; in_valid = 1;
      check(!in_ready && busy, "R5 busy/ready", {in_ready, busy}, 2'b01);
    end else begin
      in_valid = 0;
    end
    while (!out_valid && n < 20) begin
      @(posedge clk); n++; @(negedge clk);
    end
    check(n == (sg ? 6 : 4), "R4 latency", n, sg ? 6 : 4);
    check(out_prod == e[31:0], sg ? "R3 signed product" : "R2 unsigned product",
          out_prod, e);
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
      check(out_valid && out_prod == e[31:0], "R6 hold under back-pressure",
            out_prod, e);
    end
    in_valid = 0;
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    check(!out_valid && !busy && in_ready, "R7 return to idle",
          {out_valid, busy, in_ready}, 3'b001);
  endtask

  task automatic run_small(logic [5:0] a, logic [5:0] b, bit sg);
    int n = 0;
    longint e = ref_prod(a, b, sg, 6);
    @(negedge clk);
    s_a = a; s_b = b; s_signed = sg; s_valid = 1;
    @(posedge clk); @(negedge clk);
    s_valid = 0;
    while (!s_ovalid && n < 20) begin
      @(posedge clk); n++; @(negedge clk);
    end
    check(n == (sg ? 6 : 4), "R4 latency small", n, sg ? 6 : 4);
    check(s_prod == e[11:0], sg ? "R3 signed small" : "R2 unsigned small", s_prod, e);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] ra, rb;
    #1;
    check(!out_valid && !busy && in_ready, "R1 reset state",
          {out_valid, busy, in_ready}, 3'b001);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check(!out_valid && !busy && in_ready, "R1 after release",
          {out_valid, busy, in_ready}, 3'b001);

    for (int sg = 0; sg < 2; sg++) begin
      run_op(16'h8000, 16'h8000, sg[0], 0, 0);
      run_op(16'hFFFF, 16'hFFFF, sg[0], 0, 0);
      run_op(16'h0000, 16'h0000, sg[0], 0, 0);
      run_op(16'h0000, 16'hFFFF, sg[0], 0, 0);
      run_op(16'h8000, 16'h7FFF, sg[0], 0, 0);
      run_op(16'h7FFF, 16'h7FFF, sg[0], 0, 0);
      run_op(16'h00FF, 16'hFF00, sg[0], 0, 0);
      run_op(16'hFFFF, 16'h0001, sg[0], 0, 0);
    end
    run_op(16'h1234, 16'hFEDC, 1, 3, 0);
    run_op(16'hABCD, 16'h0F0F, 0, 2, 0);
    run_op(16'h9876, 16'h5432, 0, 0, 1);
    run_op(16'hC001, 16'h8FFF, 1, 1, 1);

    ra = 16'hACE1; rb = 16'h1D2B;
    for (int i = 0; i < 200; i++) begin
      ra = {ra[14:0], ra[15] ^ ra[13] ^ ra[12] ^ ra[10]};
      rb = rb * 16'd25173 + 16'd13849;
      run_op(ra, rb, i[0], 0, 0);
    end

    for (int sg = 0; sg < 2; sg++)
      for (int a = 0; a < 64; a++)
        for (int b = 0; b < 64; b++)
          run_small(a[5:0], b[5:0], sg[0]);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule